// File: doc/BRIEF.md
# Permission Trie Walker

This block resolves the 2-bit access right of one 32-bit word address inside a chosen protection domain by walking a three-level permission tree held in memory. It sits behind a permission cache as its refill engine. A lookup carries an address and a domain number. The walker picks that domain's table root from a set of per-domain base inputs. It then reads one entry per level over a simple single-word memory port, and it reports either a permission or a fault for a malformed table.

An upper-level entry is either a data entry or a pointer. A data entry gives one permission to the whole region that it spans, which is 256 KB at the first level and 256 B at the second. A pointer names the table at the next level. The third level needs no type field. Each of its memory words packs sixteen 2-bit word permissions, so regions can start and end on any 4-byte boundary. The walk stops at the first data entry, so a large uniform region costs a single read.

Top module: `perm_trie_walker`

## Requirements
- R1: While reset is held and directly after it, reqReady is 1, and doneValid and memReqValid are 0.
- R2: The first read goes to the selected domain's base, where domain d uses bits [32d+31:32d] of domainBases, plus 4 times the address bits [31:18].
- R3: Upper-level entry bits [1:0] set the entry type. The value 01 is a data entry whose permission is in bits [3:2], and the walk ends there. The value 10 is a pointer whose next table starts at the entry with bits [3:0] cleared. The values 00 and 11 end the walk with doneFault=1.
- R4: A second-level read goes to the pointer plus 4 times the address bits [17:8].
- R5: A third-level read goes to the pointer plus 4 times the address bits [7:6]. The permission is bits [2k+1:2k] of the returned word, where k is the address bits [5:2].
- R6: The permission code is 00 none, 01 read-only, 10 read-write and 11 execute-read, and it is returned unchanged.
- R7: At most one memory read is outstanding, and a walk of L levels issues exactly L reads.
- R8: reqReady is 1 only while idle. A request presented during a walk is ignored, so the result, its address and the read count belong to the accepted request only.
- R9: doneValid is high for exactly one cycle. doneAddr is the accepted request address. On a fault donePerm is 00.
- R10: With a memory that answers one cycle after the request, doneValid is sampled after the 2L+1-th rising edge, counting the accepting edge as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request present |
| reqReady | output | 1 | Walker idle, request accepted this cycle |
| reqAddr | input | 32 | Word address to resolve |
| reqDomain | input | 2 | Protection domain number |
| domainBases | input | 128 | Per-domain first-level table roots, domain 0 in the low bits |
| memReqValid | output | 1 | Single-cycle read request |
| memReqAddr | output | 32 | Byte address of the word to read |
| memRspValid | input | 1 | Read data present |
| memRspData | input | 32 | Read data |
| doneValid | output | 1 | Result pulse |
| donePerm | output | 2 | Resolved permission |
| doneFault | output | 1 | Malformed table entry met |
| doneAddr | output | 32 | Address of the resolved request |

## Verification
Each level costs two cycles, one to issue the read and one to take the response. The result therefore appears 2L+1 rising edges after acceptance, where L is the depth at which the walk stopped, and it is gone one edge later. The bench counts edges from the accepting edge and samples on falling edges. It compares that count with the depth that each vector expects. It also counts the reads seen between acceptance and the pulse, and it checks that the output is low on the following cycle and that nothing else happens after a request is presented while the walker is busy.

// File: rtl/perm_walk_pkg.sv
package perm_walk_pkg;
  localparam int PERM_W = 2;
  localparam int TYPE_W = 2;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b10,
    PERM_XR   = 2'b11
  } perm_e;

  typedef enum logic [1:0] {
    KIND_BAD  = 2'd0,
    KIND_DATA = 2'd1,
    KIND_PTR  = 2'd2
  } entry_kind_e;

  typedef enum logic [1:0] {
    LVL_ONE   = 2'd0,
    LVL_TWO   = 2'd1,
    LVL_THREE = 2'd2
  } walk_level_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LVL1,
    ST_LVL2,
    ST_LVL3,
    ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic        capture;
    logic        loadPtr;
    logic        loadUpperPerm;
    logic        loadLeafPerm;
    logic        loadFault;
    walk_level_e lvl;
  } walk_strobe_t;
endpackage

// File: rtl/perm_walk_dp.sv
module perm_walk_dp
  import perm_walk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_DOMAINS = 4,
  parameter int DOM_W       = 2,
  parameter int L1_LSB      = 18,
  parameter int L2_LSB      = 8,
  parameter int L3_LSB      = 6,
  parameter int WORD_LSB    = 2,
  parameter int PTR_ALIGN   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  walk_strobe_t                  strobe,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [DOM_W-1:0]              reqDomain,
  input  logic [NUM_DOMAINS*ADDR_W-1:0] domainBases,
  input  logic [ADDR_W-1:0]             memRspData,
  output logic [ADDR_W-1:0]             memReqAddr,
  output entry_kind_e                   rspKind,
  output logic [PERM_W-1:0]             donePerm,
  output logic                          doneFault,
  output logic [ADDR_W-1:0]             doneAddr
);
  localparam int FIELD_IDX_W = L3_LSB - WORD_LSB;

  logic [ADDR_W-1:0]      addrQ;
  logic [DOM_W-1:0]       domQ;
  logic [ADDR_W-1:0]      ptrQ;
  logic [PERM_W-1:0]      permQ;
  logic                   faultQ;
  logic [ADDR_W-1:0]      rootBase;
  logic [ADDR_W-1:0]      l1Off, l2Off, l3Off;
  logic [FIELD_IDX_W-1:0] fieldIdx;
  logic [PERM_W-1:0]      leafPerm;

  assign rootBase = domainBases[int'(domQ)*ADDR_W +: ADDR_W];
  assign l1Off    = ADDR_W'({addrQ[ADDR_W-1:L1_LSB], {WORD_LSB{1'b0}}});
  assign l2Off    = ADDR_W'({addrQ[L1_LSB-1:L2_LSB], {WORD_LSB{1'b0}}});
  assign l3Off    = ADDR_W'({addrQ[L2_LSB-1:L3_LSB], {WORD_LSB{1'b0}}});
  assign fieldIdx = addrQ[L3_LSB-1:WORD_LSB];
  assign leafPerm = memRspData[int'(fieldIdx)*PERM_W +: PERM_W];

  always_comb begin
    unique case (strobe.lvl)
      LVL_ONE: memReqAddr = rootBase + l1Off;
      LVL_TWO: memReqAddr = ptrQ + l2Off;
      default: memReqAddr = ptrQ + l3Off;
    endcase
  end

  always_comb begin
    unique case (memRspData[TYPE_W-1:0])
      2'b01:   rspKind = KIND_DATA;
      2'b10:   rspKind = KIND_PTR;
      default: rspKind = KIND_BAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      domQ   <= '0;
      ptrQ   <= '0;
      permQ  <= PERM_NONE;
      faultQ <= 1'b0;
    end else begin
      if (strobe.capture) begin
        addrQ  <= reqAddr;
        domQ   <= reqDomain;
        faultQ <= 1'b0;
      end
      if (strobe.loadPtr)
        ptrQ <= {memRspData[ADDR_W-1:PTR_ALIGN], {PTR_ALIGN{1'b0}}};
      if (strobe.loadUpperPerm) begin
        permQ  <= memRspData[TYPE_W +: PERM_W];
        faultQ <= 1'b0;
      end
      if (strobe.loadLeafPerm) begin
        permQ  <= leafPerm;
        faultQ <= 1'b0;
      end
      if (strobe.loadFault) begin
        permQ  <= PERM_NONE;
        faultQ <= 1'b1;
      end
    end
  end

  assign donePerm  = permQ;
  assign doneFault = faultQ;
  assign doneAddr  = addrQ;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(addrQ)); // R9
  AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (!rstN)
    faultQ |-> (permQ == PERM_NONE)); // R9
endmodule

// File: rtl/perm_walk_ctrl.sv
module perm_walk_ctrl
  import perm_walk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memRspValid,
  input  entry_kind_e  rspKind,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         doneValid,
  output walk_strobe_t strobe
);
  walk_state_e stateQ, stateD;
  logic        issuedQ;
  logic        rspTake;

  assign rspTake     = issuedQ && memRspValid;
  assign reqReady    = (stateQ == ST_IDLE);
  assign doneValid   = (stateQ == ST_DONE);
  assign memReqValid = !issuedQ &&
                       (stateQ == ST_LVL1 || stateQ == ST_LVL2 || stateQ == ST_LVL3);

  always_comb begin
    stateD     = stateQ;
    strobe     = '0;
    strobe.lvl = LVL_ONE;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateD         = ST_LVL1;
        end
      end
      ST_LVL1, ST_LVL2: begin
        strobe.lvl = (stateQ == ST_LVL1) ? LVL_ONE : LVL_TWO;
        if (rspTake) begin
          unique case (rspKind)
            KIND_DATA: begin
              strobe.loadUpperPerm = 1'b1;
              stateD               = ST_DONE;
            end
            KIND_PTR: begin
              strobe.loadPtr = 1'b1;
              stateD         = (stateQ == ST_LVL1) ? ST_LVL2 : ST_LVL3;
            end
            default: begin
              strobe.loadFault = 1'b1;
              stateD           = ST_DONE;
            end
          endcase
        end
      end
      ST_LVL3: begin
        strobe.lvl = LVL_THREE;
        if (rspTake) begin
          strobe.loadLeafPerm = 1'b1;
          stateD              = ST_DONE;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      issuedQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (memReqValid)
        issuedQ <= 1'b1;
      else if (rspTake)
        issuedQ <= 1'b0;
    end
  end

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid); // R7
  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R9
endmodule

// File: rtl/perm_trie_walker.sv
module perm_trie_walker
  import perm_walk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_DOMAINS = 4,
  parameter int L1_LSB      = 18,
  parameter int L2_LSB      = 8,
  parameter int L3_LSB      = 6,
  parameter int WORD_LSB    = 2,
  parameter int PTR_ALIGN   = 4,
  localparam int DOM_W      = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [DOM_W-1:0]              reqDomain,
  input  logic [NUM_DOMAINS*ADDR_W-1:0] domainBases,
  output logic                          memReqValid,
  output logic [ADDR_W-1:0]             memReqAddr,
  input  logic                          memRspValid,
  input  logic [ADDR_W-1:0]             memRspData,
  output logic                          doneValid,
  output logic [PERM_W-1:0]             donePerm,
  output logic                          doneFault,
  output logic [ADDR_W-1:0]             doneAddr
);
  walk_strobe_t strobe;
  entry_kind_e  rspKind;

  perm_walk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .rspKind     (rspKind),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .doneValid   (doneValid),
    .strobe      (strobe)
  );

  perm_walk_dp #(
    .ADDR_W      (ADDR_W),
    .NUM_DOMAINS (NUM_DOMAINS),
    .DOM_W       (DOM_W),
    .L1_LSB      (L1_LSB),
    .L2_LSB      (L2_LSB),
    .L3_LSB      (L3_LSB),
    .WORD_LSB    (WORD_LSB),
    .PTR_ALIGN   (PTR_ALIGN)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqDomain   (reqDomain),
    .domainBases (domainBases),
    .memRspData  (memRspData),
    .memReqAddr  (memReqAddr),
    .rspKind     (rspKind),
    .donePerm    (donePerm),
    .doneFault   (doneFault),
    .doneAddr    (doneAddr)
  );
endmodule

// File: tb/perm_trie_walker_bench.sv
module perm_trie_walker_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [31:0]  reqAddr = '0;
  logic [1:0]   reqDomain = '0;
  logic [127:0] domainBases;
  logic         memReqValid;
  logic [31:0]  memReqAddr;
  logic         memRspValid;
  logic [31:0]  memRspData;
  logic         doneValid;
  logic [1:0]   donePerm;
  logic         doneFault;
  logic [31:0]  doneAddr;

  int compared = 0;
  int mismatched = 0;
  int readCount = 0;
  logic prevReq = 1'b0;
  logic overlapSeen = 1'b0;
  logic [31:0] mem [logic [31:0]];

  always #5 clk = ~clk;

  assign domainBases = {32'h4000_0000, 32'h3000_0000, 32'h2000_0000, 32'h1000_0000};

  perm_trie_walker u_perm_trie_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqDomain(reqDomain), .domainBases(domainBases),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .doneValid(doneValid), .donePerm(donePerm), .doneFault(doneFault),
    .doneAddr(doneAddr)
  );

  function automatic logic [31:0] rdMem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // One-cycle memory: answers the cycle after each request.
  always @(posedge clk) begin
    if (!rstN) begin
      memRspValid <= 1'b0;
      memRspData  <= 32'h0;
      prevReq     <= 1'b0;
    end else begin
      memRspValid <= memReqValid;
      memRspData  <= memReqValid ? rdMem(memReqAddr) : 32'hDEAD_BEEF;
      if (memReqValid) readCount <= readCount + 1;
      if (memReqValid && prevReq) overlapSeen <= 1'b1;
      prevReq <= memReqValid;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  dom;
    logic [1:0]  perm;
    logic        fault;
    logic [1:0]  lvls;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h0004_0123, 2'd0, 2'b10, 1'b0, 2'd1},
    '{32'h0004_0000, 2'd1, 2'b11, 1'b0, 2'd1},
    '{32'h0000_0010, 2'd0, 2'b00, 1'b1, 2'd1},
    '{32'hFFFC_0008, 2'd3, 2'b01, 1'b0, 2'd1},
    '{32'h0004_0000, 2'd2, 2'b00, 1'b1, 2'd1},
    '{32'h0008_0300, 2'd0, 2'b01, 1'b0, 2'd2},
    '{32'h0008_0500, 2'd0, 2'b00, 1'b1, 2'd2},
    '{32'h0008_0600, 2'd0, 2'b00, 1'b0, 2'd2},
    '{32'h0008_0440, 2'd0, 2'b00, 1'b0, 2'd3},
    '{32'h0008_0444, 2'd0, 2'b01, 1'b0, 2'd3},
    '{32'h0008_0448, 2'd0, 2'b10, 1'b0, 2'd3},
    '{32'h0008_044C, 2'd0, 2'b11, 1'b0, 2'd3},
    '{32'h0008_047C, 2'd0, 2'b11, 1'b0, 2'd3},
    '{32'h0008_04C0, 2'd0, 2'b01, 1'b0, 2'd3},
    '{32'h0008_04FC, 2'd0, 2'b10, 1'b0, 2'd3}
  };

  task automatic runWalk(input logic [31:0] a, input logic [1:0] d, input logic inject,
                         output logic [1:0] p, output logic f, output logic [31:0] da,
                         output int lat, output int reads);
    int startReads;
    @(negedge clk);
    startReads = readCount;
    reqAddr = a; reqDomain = d; reqValid = 1'b1; lat = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (inject) reqAddr = a ^ 32'h000C_0000; else reqValid = 1'b0;
      if (doneValid) break;
    end
    check(doneValid, "R10 walk timeout", {31'b0, doneValid}, 32'h1);
    p = donePerm; f = doneFault; da = doneAddr;
    reads = readCount - startReads;
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [1:0] p; logic f; logic [31:0] da; int lat; int reads;
    mem[32'h1000_0004] = 32'h0000_0009;  // d0 L1 idx1: data RW
    mem[32'h2000_0004] = 32'h0000_000D;  // d1 L1 idx1: data XR
    mem[32'h4000_FFFC] = 32'h0000_0005;  // d3 L1 top idx: data RO
    mem[32'h1000_0008] = 32'h5000_0002;  // d0 L1 idx2: pointer
    mem[32'h5000_000C] = 32'h0000_0005;  // L2 idx3: data RO
    mem[32'h5000_0010] = 32'h6000_001E;  // L2 idx4: pointer, low bits set (R3)
    mem[32'h5000_0014] = 32'h0000_0003;  // L2 idx5: malformed
    mem[32'h5000_0018] = 32'h0000_0001;  // L2 idx6: data none
    mem[32'h6000_0014] = 32'hE4E4_E4E4;
    mem[32'h6000_001C] = 32'h8000_0001;

    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1 ready in reset", {31'b0, reqReady}, 32'h1);
    check(doneValid == 1'b0, "R1 done in reset", {31'b0, doneValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(memReqValid == 1'b0, "R1 no read after reset", {31'b0, memReqValid}, 32'h0);
    check(reqReady == 1'b1, "R1 ready after reset", {31'b0, reqReady}, 32'h1);

    for (int v = 0; v < NV; v++) begin
      runWalk(VECS[v].addr, VECS[v].dom, 1'b0, p, f, da, lat, reads);
      check(p == VECS[v].perm, "R6 perm", {30'b0, p}, {30'b0, VECS[v].perm});
      check(f == VECS[v].fault, "R3 fault", {31'b0, f}, {31'b0, VECS[v].fault});
      check(da == VECS[v].addr, "R9 address", da, VECS[v].addr);
      check(lat == 2 * int'(VECS[v].lvls) + 1, "R10 latency", lat,
            2 * int'(VECS[v].lvls) + 1);
      if (VECS[v].lvls == 2'd1)
        check(reads == 1, "R2 reads", reads, 1);
      else if (VECS[v].lvls == 2'd2)
        check(reads == 2, "R4 reads", reads, 2);
      else
        check(reads == 3, "R5 reads", reads, 3);
    end

    // R8: request held with changing address during a three-level walk
    runWalk(32'h0008_044C, 2'd0, 1'b1, p, f, da, lat, reads);
    check(da == 32'h0008_044C, "R8 address kept", da, 32'h0008_044C);
    check(p == 2'b11, "R8 perm kept", {30'b0, p}, 32'h3);
    check(reads == 3, "R8 read count", reads, 3);
    @(negedge clk);
    check(doneValid == 1'b0, "R9 pulse width", {31'b0, doneValid}, 32'h0);
    check(reqReady == 1'b1, "R8 idle again", {31'b0, reqReady}, 32'h1);
    begin
      int extra = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (doneValid || memReqValid) extra++;
      end
      check(extra == 0, "R8 ignored request", extra, 0);
    end
    check(!overlapSeen, "R7 single outstanding", {31'b0, overlapSeen}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule